// File: doc/BRIEF.md
# Write-Only Serial Control Register Bank for a Three-Channel Video Path

This block is an I2C slave that accepts write transfers from a host microcontroller and holds the control settings of a three-channel video amplifier as parallel register outputs. These settings are contrast, brightness, one gain per colour channel, an output DC level, an overlay contrast, and a byte of mode bits. The block samples SCL and SDA with the system clock through two-flop synchronizers. It acknowledges a transfer by pulling SDA low through an open-drain enable, so the pad drives low only when `sda_oe_o` is 1.

A host write is a START, the device byte 0xDC (7-bit address 0x6E with R/W = 0), a sub-address byte, one data byte and a STOP. All bytes arrive MSB first. The block acknowledges every byte that it accepts. It never returns data. Each register comes out of reset at its own non-zero value, so the video path starts in a usable state before any host access.

Top module: `vctl_i2c_regs`

## Requirements
- R1: After reset the outputs hold: contrast, brightness and the three drive gains 0xB4; DC level and overlay contrast 0x8; mode byte 0x04.
- R2: A transfer START, 0xDC, sub-address, data, STOP has all three bytes acknowledged and stores the data (MSB first) in the register selected by the sub-address. The map is 01 contrast, 02 brightness, 03/04/05 drive of channel 1/2/3, 06 DC level, 07 overlay contrast, 08 mode byte.
- R3: The acknowledge holds SDA low for the whole high phase of the ninth SCL pulse. The enable changes only while SCL is low, and SDA is released after that pulse's falling edge.
- R4: A device byte other than 0xDC, including 0xDD (read), is not acknowledged. The following bytes are not acknowledged either and change no register until the next START.
- R5: Sub-addresses 06 and 07 store only bits 3:0 of the data byte.
- R6: Sub-address 00 or any value above 08 is acknowledged and its data byte is acknowledged, but no register changes.
- R7: A byte sent after the data byte and before STOP is not acknowledged and is not stored.
- R8: A START that arrives before a transfer completes drops any partly received byte, stores nothing, and restarts the device-byte phase.
- R9: START is SDA falling and STOP is SDA rising, each while SCL is high. After a STOP, bytes sent without a new START are not acknowledged and are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| contrast_o | output | 8 | Common contrast gain |
| brightness_o | output | 8 | Common brightness offset |
| drive1_o | output | 8 | Channel 1 drive gain |
| drive2_o | output | 8 | Channel 2 drive gain |
| drive3_o | output | 8 | Channel 3 drive gain |
| dc_level_o | output | 4 | Output DC level |
| osd_gain_o | output | 4 | Overlay contrast |
| misc_o | output | 8 | Mode byte: bit 0 clamp-pulse source, bits 2:1 clamp-pulse width, bit 6 semi-transparent overlay |

## Verification
The hardest case to reach from the ports is a START that arrives partway through a byte, after some bits have already been shifted in. Without it, the dropping of a partial byte in R8 is never tested. The stimulus builds this with a bit-level bus task. The task stops after a chosen number of data bits, raises SDA while SCL is low, and then issues a START. This is done in the device-byte phase and in the data phase. A clean write follows each interrupted one, so a lost or misplaced value shows up in the reference model that is compared on every clock.

// File: rtl/vctl_pkg.sv
package vctl_pkg;
    localparam int NREG = 8;
    localparam int BYTE_W = 8;
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [BYTE_W-1:0] DEV_WR_BYTE = 8'hDC;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_SUB, ST_DATA, ST_ACK, ST_HOLD
    } bus_st_e;

    typedef struct packed {
        bus_st_e            st;
        bus_st_e            after;
        logic [BYTE_W-1:0]  sh;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  sub;
        logic               oe;
        logic               scl_p;
        logic               sda_p;
        logic               wr_en;
        logic [BYTE_W-1:0]  wr_addr;
        logic [BYTE_W-1:0]  wr_data;
    } fsm_t;

    function automatic logic [BYTE_W-1:0] reg_reset(input int idx);
        if (idx <= 5)      return 8'hB4;
        else if (idx <= 7) return 8'h08;
        else               return 8'h04;
    endfunction

    function automatic logic [BYTE_W-1:0] reg_mask(input int idx);
        return (idx == 6 || idx == 7) ? 8'h0F : 8'hFF;
    endfunction
endpackage

// File: rtl/vctl_sync.sv
module vctl_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= '1;
        end else begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_d[s];
        end
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/vctl_bus_fsm.sv
module vctl_bus_fsm
    import vctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    output logic              sda_oe_o,
    output logic              wr_en_o,
    output logic [BYTE_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o
);
    fsm_t q, n;
    logic scl_rise, scl_fall, start_w, stop_w;

    always_comb begin
        scl_rise = scl_s & ~q.scl_p;
        scl_fall = ~scl_s & q.scl_p;
        start_w  = scl_s & q.scl_p & q.sda_p & ~sda_s;
        stop_w   = scl_s & q.scl_p & ~q.sda_p & sda_s;

        n       = q;
        n.scl_p = scl_s;
        n.sda_p = sda_s;
        n.wr_en = 1'b0;

        if (start_w) begin
            n.st  = ST_ADDR;
            n.cnt = '0;
            n.sh  = '0;
            n.oe  = 1'b0;
        end else if (stop_w) begin
            n.st = ST_IDLE;
            n.oe = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_SUB, ST_DATA: begin
                    if (scl_rise && q.cnt < CNT_W'(BYTE_W)) begin
                        n.sh  = {q.sh[BYTE_W-2:0], sda_s};
                        n.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == CNT_W'(BYTE_W)) begin
                        n.cnt = '0;
                        if (q.st == ST_ADDR) begin
                            if (q.sh == DEV_WR_BYTE) begin
                                n.oe    = 1'b1;
                                n.st    = ST_ACK;
                                n.after = ST_SUB;
                            end else begin
                                n.st = ST_HOLD;
                            end
                        end else if (q.st == ST_SUB) begin
                            n.sub   = q.sh;
                            n.oe    = 1'b1;
                            n.st    = ST_ACK;
                            n.after = ST_DATA;
                        end else begin
                            n.oe    = 1'b1;
                            n.st    = ST_ACK;
                            n.after = ST_HOLD;
                            if (q.sub != '0 && q.sub <= BYTE_W'(NREG)) begin
                                n.wr_en   = 1'b1;
                                n.wr_addr = q.sub;
                                n.wr_data = q.sh;
                            end
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        n.oe  = 1'b0;
                        n.st  = q.after;
                        n.cnt = '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, after: ST_IDLE, sh: '0, cnt: '0, sub: '0,
                   oe: 1'b0, scl_p: 1'b1, sda_p: 1'b1, wr_en: 1'b0,
                   wr_addr: '0, wr_data: '0};
        end else begin
            q <= n;
        end
    end

    assign sda_oe_o  = q.oe;
    assign wr_en_o   = q.wr_en;
    assign wr_addr_o = q.wr_addr;
    assign wr_data_o = q.wr_data;

    AST_ACK_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.oe) |-> !scl_s);  // R3
    AST_WRITE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr_en |-> (q.oe && q.st == ST_ACK));  // R2
    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_w) |-> (q.st == ST_ADDR && q.cnt == '0 && !q.oe));  // R8
    AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_w) |-> (q.st == ST_IDLE && !q.oe));  // R9
    AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_HOLD) |-> (!q.oe && !q.wr_en));  // R4
endmodule

// File: rtl/vctl_regfile.sv
module vctl_regfile
    import vctl_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en_i,
    input  logic [BYTE_W-1:0]            wr_addr_i,
    input  logic [BYTE_W-1:0]            wr_data_i,
    output logic [NREG-1:0][BYTE_W-1:0]  regs_o
);
    logic [NREG-1:0][BYTE_W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NREG; i++) begin
            if (wr_en_i && wr_addr_i == BYTE_W'(i + 1))
                regs_d[i] = wr_data_i & reg_mask(i + 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= reg_reset(i + 1);
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs_o = regs_q;

    for (genvar g = 0; g < NREG; g++) begin : g_chk
        AST_REG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en_i && wr_addr_i == BYTE_W'(g + 1)) |=> $stable(regs_q[g]));  // R6
    end
endmodule

// File: rtl/vctl_i2c_regs.sv
module vctl_i2c_regs
    import vctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    output logic [7:0] contrast_o,
    output logic [7:0] brightness_o,
    output logic [7:0] drive1_o,
    output logic [7:0] drive2_o,
    output logic [7:0] drive3_o,
    output logic [3:0] dc_level_o,
    output logic [3:0] osd_gain_o,
    output logic [7:0] misc_o
);
    logic [1:0]                  bus_s;
    logic                        wr_en;
    logic [BYTE_W-1:0]           wr_addr, wr_data;
    logic [NREG-1:0][BYTE_W-1:0] regs;

    vctl_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i({scl_i, sda_i}), .sync_o(bus_s)
    );

    vctl_bus_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_s(bus_s[1]), .sda_s(bus_s[0]),
        .sda_oe_o(sda_oe_o), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
        .wr_data_o(wr_data)
    );

    vctl_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .regs_o(regs)
    );

    assign contrast_o   = regs[0];
    assign brightness_o = regs[1];
    assign drive1_o     = regs[2];
    assign drive2_o     = regs[3];
    assign drive3_o     = regs[4];
    assign dc_level_o   = regs[5][3:0];
    assign osd_gain_o   = regs[6][3:0];
    assign misc_o       = regs[7];

    AST_NIBBLE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (regs[5][7:4] == 4'h0 && regs[6][7:4] == 4'h0));  // R5
endmodule

// File: tb/vctl_i2c_regs_tb.sv
`timescale 1ns/1ps
module vctl_i2c_regs_tb_top;
    localparam int Q = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [7:0] contrast, brightness, drive1, drive2, drive3, misc;
    logic [3:0] dc_level, osd_gain;

    assign sda_line = sda_m & ~sda_oe;

    vctl_i2c_regs dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .contrast_o(contrast), .brightness_o(brightness),
        .drive1_o(drive1), .drive2_o(drive2), .drive3_o(drive3),
        .dc_level_o(dc_level), .osd_gain_o(osd_gain), .misc_o(misc)
    );

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    logic [7:0] exp_reg [1:8];

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic [7:0] act, input logic [7:0] exp,
                       input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] out_of(input int i);
        case (i)
            1: return contrast;
            2: return brightness;
            3: return drive1;
            4: return drive2;
            5: return drive3;
            6: return {4'h0, dc_level};
            7: return {4'h0, osd_gain};
            default: return misc;
        endcase
    endfunction

    // reference model compared on every clock
    always @(negedge clk) begin
        if (rst_n && cmp_en)
            for (int i = 1; i <= 8; i++)
                chk(out_of(i), exp_reg[i], "R2 R5 R6", $sformatf("reg %0d", i));
    end

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i >= 8 - n; i--) begin
            sda_m = b[i]; tick(Q);
            scl = 1'b1;   tick(2 * Q);
            if (i == 0) cmp_en = 1'b0;
            scl = 1'b0;   tick(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack,
                             input string req, input bit hold);
        logic first;
        send_bits(b, 8);
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        first = sda_line;
        chk({7'd0, ~first}, {7'd0, exp_ack}, req, $sformatf("ack for %h", b));
        tick(Q);
        chk({7'd0, sda_line}, {7'd0, first}, "R3", "SDA stable in ack high phase");
        scl = 1'b0;   tick(Q);
        chk({7'd0, sda_oe}, 8'd0, "R3", "SDA released after ack");
        if (!hold) cmp_en = 1'b1;
    endtask

    task automatic commit(input logic [7:0] sub, input logic [7:0] data);
        if (sub >= 1 && sub <= 8)
            exp_reg[sub] = data & ((sub == 6 || sub == 7) ? 8'h0F : 8'hFF);
        cmp_en = 1'b1;
    endtask

    task automatic wr(input logic [7:0] sub, input logic [7:0] data, input string req);
        bus_start();
        send_byte(8'hDC, 1'b1, req, 1'b0);
        send_byte(sub, 1'b1, req, 1'b0);
        send_byte(data, 1'b1, req, 1'b1);
        commit(sub, data);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R1: reset values
        chk(contrast, 8'hB4, "R1", "contrast reset");
        chk(brightness, 8'hB4, "R1", "brightness reset");
        chk(drive1, 8'hB4, "R1", "drive1 reset");
        chk(drive2, 8'hB4, "R1", "drive2 reset");
        chk(drive3, 8'hB4, "R1", "drive3 reset");
        chk({4'h0, dc_level}, 8'h08, "R1", "dc reset");
        chk({4'h0, osd_gain}, 8'h08, "R1", "osd reset");
        chk(misc, 8'h04, "R1", "misc reset");
        chk({7'd0, sda_oe}, 8'd0, "R1", "sda idle");
        for (int i = 1; i <= 5; i++) exp_reg[i] = 8'hB4;
        exp_reg[6] = 8'h08; exp_reg[7] = 8'h08; exp_reg[8] = 8'h04;
        cmp_en = 1'b1;

        // R2: every sub-address
        wr(8'h01, 8'h5A, "R2");
        wr(8'h02, 8'hC3, "R2");
        wr(8'h03, 8'h01, "R2");
        wr(8'h04, 8'hFE, "R2");
        wr(8'h05, 8'h80, "R2");
        wr(8'h08, 8'h47, "R2");
        // R5: nibble registers
        wr(8'h06, 8'hA7, "R5");
        wr(8'h07, 8'hFF, "R5");

        // R4: wrong address then read address
        bus_start();
        send_byte(8'hDE, 1'b0, "R4", 1'b0);
        send_byte(8'h01, 1'b0, "R4", 1'b0);
        send_byte(8'h00, 1'b0, "R4", 1'b0);
        bus_stop();
        bus_start();
        send_byte(8'hDD, 1'b0, "R4", 1'b0);
        send_byte(8'h02, 1'b0, "R4", 1'b0);
        bus_stop();
        chk(contrast, 8'h5A, "R4", "contrast after ignored transfer");

        // R6: out-of-map sub-addresses
        wr(8'h00, 8'h11, "R6");
        wr(8'h09, 8'h22, "R6");
        wr(8'hFF, 8'h33, "R6");

        // R7: extra byte after data
        bus_start();
        send_byte(8'hDC, 1'b1, "R7", 1'b0);
        send_byte(8'h02, 1'b1, "R7", 1'b0);
        send_byte(8'h33, 1'b1, "R7", 1'b1);
        commit(8'h02, 8'h33);
        send_byte(8'h44, 1'b0, "R7", 1'b0);
        bus_stop();
        chk(brightness, 8'h33, "R7", "brightness keeps first data");

        // R8: repeated START mid data byte
        bus_start();
        send_byte(8'hDC, 1'b1, "R8", 1'b0);
        send_byte(8'h03, 1'b1, "R8", 1'b0);
        send_bits(8'h99, 5);
        bus_start();
        send_byte(8'hDC, 1'b1, "R8", 1'b0);
        send_byte(8'h04, 1'b1, "R8", 1'b0);
        send_byte(8'h21, 1'b1, "R8", 1'b1);
        commit(8'h04, 8'h21);
        bus_stop();
        chk(drive1, 8'h01, "R8", "drive1 not hit by dropped byte");
        chk(drive2, 8'h21, "R8", "drive2 after restart");
        // R8: repeated START mid address byte
        bus_start();
        send_bits(8'hDC, 4);
        bus_start();
        send_byte(8'hDC, 1'b1, "R8", 1'b0);
        send_byte(8'h05, 1'b1, "R8", 1'b0);
        send_byte(8'h66, 1'b1, "R8", 1'b1);
        commit(8'h05, 8'h66);
        bus_stop();
        chk(drive3, 8'h66, "R8", "drive3 after address restart");
        // R8: repeated START right after sub-address ack
        bus_start();
        send_byte(8'hDC, 1'b1, "R8", 1'b0);
        send_byte(8'h01, 1'b1, "R8", 1'b0);
        bus_start();
        send_byte(8'hDC, 1'b1, "R8", 1'b0);
        send_byte(8'h01, 1'b1, "R8", 1'b0);
        send_byte(8'h77, 1'b1, "R8", 1'b1);
        commit(8'h01, 8'h77);
        bus_stop();

        // R9: bytes after STOP without START
        scl = 1'b0; tick(Q);
        send_byte(8'hDC, 1'b0, "R9", 1'b0);
        bus_start();
        send_byte(8'hDC, 1'b1, "R9", 1'b0);
        send_byte(8'h06, 1'b1, "R9", 1'b0);
        bus_stop();
        scl = 1'b0; tick(Q);
        send_byte(8'h05, 1'b0, "R9", 1'b0);
        bus_stop();
        chk({4'h0, dc_level}, 8'h07, "R9", "dc level unchanged after STOP");
        wr(8'h08, 8'h41, "R9");

        tick(4 * Q);
        for (int i = 1; i <= 8; i++)
            chk(out_of(i), exp_reg[i], "R2", $sformatf("final reg %0d", i));
        cmp_en = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule